// File: doc/BRIEF.md
# Pin Test Mode Controller

This block chooses, for every pin of a chip, whether the pin follows its functional logic, takes part in a board-level connectivity test, or is released to high impedance. On each rising edge of the crystal clock it samples an active-low reset and two active-low enables, one for the connectivity test and one for three-state. From these it updates a two-bit mode register. The register powers up in normal mode, so the pins work as usual until a qualifying edge arrives.

In connectivity test mode every ordinary pin stops driving and acts as an input. A single dedicated result pin then drives the AND of all the ordinary pin inputs. The result path is combinational, so board test equipment can pull one pin low at a time and watch the result pin change without any further clock. In three-state mode every output enable is off, the result pin's enable included. This lets the chip be isolated on the board.

Top module: `pin_test_ctrl`

## Requirements
- R1: After power-up, and before any qualifying clock edge, `mode` reads 2'b00 (normal). In normal mode `pin_oe` equals `func_oe`, `probe_out` equals `func_probe` and `probe_oe` equals `func_probe_oe`.
- R2: A rising `clk` edge with `rst_n` low and `tst_en_n` low puts the block in test mode. `mode` reads 2'b01 after that edge.
- R3: In test mode every bit of `pin_oe` is 0 and `probe_oe` is 1.
- R4: In test mode `probe_out` is 1 only when every bit of `pin_in` is 1, and 0 if any bit is 0. The path is combinational, so the output follows `pin_in` with no clock edge.
- R5: A rising `clk` edge with `rst_n` high or `tst_en_n` high takes the block out of test mode.
- R6: A rising `clk` edge with `rst_n` low, `hiz_en_n` low and `tst_en_n` high puts the block in three-state mode. `mode` then reads 2'b10, every bit of `pin_oe` is 0 and `probe_oe` is 0.
- R7: A rising `clk` edge where neither mode's enabling condition holds returns `mode` to 2'b00.
- R8: If `tst_en_n` and `hiz_en_n` are both low with `rst_n` low on the same edge, test mode is chosen.
- R9: `mode` changes only on a rising `clk` edge. A change of `rst_n`, `tst_en_n` or `hiz_en_n` between edges has no effect on `mode` or on the output enables until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock; the mode is sampled on its rising edge |
| rst_n | input | 1 | Active-low chip reset level, a qualifier for mode entry |
| tst_en_n | input | 1 | Active-low connectivity test enable |
| hiz_en_n | input | 1 | Active-low three-state enable |
| pin_in | input | PINS | Values read back from the ordinary pins |
| func_oe | input | PINS | Output enables requested by the functional logic |
| func_probe | input | 1 | Functional value for the result pin |
| func_probe_oe | input | 1 | Functional output enable for the result pin |
| pin_oe | output | PINS | Output enables sent to the ordinary pin pads |
| probe_out | output | 1 | Value driven on the result pin |
| probe_oe | output | 1 | Output enable of the result pin |
| mode | output | 2 | Current mode: 00 normal, 01 test, 10 three-state |

## Verification
The assertions check on every clock edge that the mode follows the sampled qualifiers, with test taking priority. They also check that the enables match the current mode, that the result pin equals the AND of the pin inputs while testing, and that the mode code is never 2'b11. Only the bench's scenarios show behaviour that happens between edges. In test mode a single low bit is walked across all sixteen pins and the combinational result is checked before any clock. Qualifiers are also moved mid-cycle, and the bench confirms that the mode and enables wait for the next edge.

// File: rtl/pin_test_ctrl.sv
module pin_test_ctrl #(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tst_en_n,
  input  logic            hiz_en_n,
  input  logic [PINS-1:0] pin_in,
  input  logic [PINS-1:0] func_oe,
  input  logic            func_probe,
  input  logic            func_probe_oe,
  output logic [PINS-1:0] pin_oe,
  output logic            probe_out,
  output logic            probe_oe,
  output logic [1:0]      mode
);
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_TEST = 2'b01;
  localparam logic [1:0] M_HIZ  = 2'b10;

  // No asynchronous reset: the register powers up in normal mode.
  logic [1:0] mode_q = M_NORM;
  logic [1:0] mode_d;

  always_comb begin
    if (!rst_n && !tst_en_n)      mode_d = M_TEST;
    else if (!rst_n && !hiz_en_n) mode_d = M_HIZ;
    else                          mode_d = M_NORM;
  end

  always_ff @(posedge clk) mode_q <= mode_d;

  wire in_test = (mode_q == M_TEST);
  wire in_norm = (mode_q == M_NORM);

  assign mode      = mode_q;
  assign pin_oe    = in_norm ? func_oe : '0;
  assign probe_out = in_test ? &pin_in : func_probe;
  assign probe_oe  = in_test ? 1'b1 : (in_norm ? func_probe_oe : 1'b0);
endmodule

// File: rtl/pin_test_ctrl_chk.sv
module pin_test_ctrl_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tst_en_n,
  input logic            hiz_en_n,
  input logic [PINS-1:0] pin_in,
  input logic [PINS-1:0] func_oe,
  input logic            func_probe_oe,
  input logic [PINS-1:0] pin_oe,
  input logic            probe_out,
  input logic            probe_oe,
  input logic [1:0]      mode
);
  // rst_n is a mode qualifier here, not a reset of this logic, so no disable is used.
  a_r1_norm_pass: assert property (@(posedge clk)
    mode == 2'b00 |-> (pin_oe == func_oe && probe_oe == func_probe_oe));
  a_r2_enter_test: assert property (@(posedge clk)
    (!rst_n && !tst_en_n) |=> mode == 2'b01);
  a_r3_test_oe: assert property (@(posedge clk)
    mode == 2'b01 |-> (pin_oe == '0 && probe_oe));
  a_r4_and_chain: assert property (@(posedge clk)
    mode == 2'b01 |-> probe_out == &pin_in);
  a_r5_leave_test: assert property (@(posedge clk)
    (rst_n || tst_en_n) |=> mode != 2'b01);
  a_r6_hiz: assert property (@(posedge clk)
    (!rst_n && !hiz_en_n && tst_en_n) |=> (mode == 2'b10 && pin_oe == '0 && !probe_oe));
  a_r7_back_norm: assert property (@(posedge clk)
    (rst_n || (tst_en_n && hiz_en_n)) |=> mode == 2'b00);
  a_r9_legal_code: assert property (@(posedge clk) $onehot0(mode));
endmodule

bind pin_test_ctrl pin_test_ctrl_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tst_en_n(tst_en_n), .hiz_en_n(hiz_en_n),
  .pin_in(pin_in), .func_oe(func_oe), .func_probe_oe(func_probe_oe),
  .pin_oe(pin_oe), .probe_out(probe_out), .probe_oe(probe_oe), .mode(mode)
);

// File: tb/pin_test_ctrl_tb.sv
module pin_test_ctrl_tb;
  localparam int PINS = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b1, tst_en_n = 1'b1, hiz_en_n = 1'b1;
  logic [PINS-1:0] pin_in = '1, func_oe = 16'hA5C3;
  logic func_probe = 1'b0, func_probe_oe = 1'b1;
  logic [PINS-1:0] pin_oe;
  logic probe_out, probe_oe;
  logic [1:0] mode;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pin_test_ctrl #(.PINS(PINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tst_en_n(tst_en_n), .hiz_en_n(hiz_en_n),
    .pin_in(pin_in), .func_oe(func_oe), .func_probe(func_probe),
    .func_probe_oe(func_probe_oe), .pin_oe(pin_oe), .probe_out(probe_out),
    .probe_oe(probe_oe), .mode(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edge_with(input logic r, input logic t, input logic h);
    rst_n = r; tst_en_n = t; hiz_en_n = h;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_powerup;
    #2;
    chk("R1 mode", mode, 2'b00);
    chk("R1 pin_oe", pin_oe, func_oe);
    chk("R1 probe_out", probe_out, func_probe);
    chk("R1 probe_oe", probe_oe, func_probe_oe);
    @(negedge clk);
  endtask

  task automatic t_walk;
    edge_with(1'b0, 1'b0, 1'b1);
    chk("R2 mode", mode, 2'b01);
    chk("R3 pin_oe", pin_oe, '0);
    chk("R3 probe_oe", probe_oe, 1'b1);
    pin_in = '1; #1;
    chk("R4 all high", probe_out, 1'b1);
    for (int i = 0; i < PINS; i++) begin
      pin_in = ~(16'h1 << i); #1;
      chk("R4 walk low", probe_out, 1'b0);
      pin_in = '1; #1;
      chk("R4 restore", probe_out, 1'b1);
    end
    pin_in = 16'h0000; #1;
    chk("R4 all low", probe_out, 1'b0);
    pin_in = '1;
    @(negedge clk);
  endtask

  task automatic t_leave_test;
    edge_with(1'b0, 1'b0, 1'b1);
    edge_with(1'b1, 1'b0, 1'b1);
    chk("R5 exit by reset high", mode, 2'b00);
    edge_with(1'b0, 1'b0, 1'b1);
    edge_with(1'b0, 1'b1, 1'b1);
    chk("R5 exit by enable high", mode, 2'b00);
    chk("R7 pin_oe back", pin_oe, func_oe);
  endtask

  task automatic t_hiz;
    func_probe_oe = 1'b1;
    edge_with(1'b0, 1'b1, 1'b0);
    chk("R6 mode", mode, 2'b10);
    chk("R6 pin_oe", pin_oe, '0);
    chk("R6 probe_oe", probe_oe, 1'b0);
    edge_with(1'b1, 1'b1, 1'b0);
    chk("R7 exit by reset high", mode, 2'b00);
    edge_with(1'b0, 1'b1, 1'b0);
    edge_with(1'b0, 1'b1, 1'b1);
    chk("R7 exit by enable high", mode, 2'b00);
    chk("R7 probe_oe back", probe_oe, 1'b1);
  endtask

  task automatic t_priority;
    edge_with(1'b0, 1'b0, 1'b0);
    chk("R8 test wins", mode, 2'b01);
    edge_with(1'b0, 1'b1, 1'b0);
    chk("R8 then hiz", mode, 2'b10);
    edge_with(1'b1, 1'b1, 1'b1);
    chk("R8 normal", mode, 2'b00);
  endtask

  task automatic t_between_edges;
    rst_n = 1'b0; tst_en_n = 1'b0; #2;
    chk("R9 no early entry", mode, 2'b00);
    chk("R9 oe held", pin_oe, func_oe);
    @(posedge clk); #1;
    chk("R9 entry at edge", mode, 2'b01);
    rst_n = 1'b1; #2;
    chk("R9 no early exit", mode, 2'b01);
    @(posedge clk); #1;
    chk("R9 exit at edge", mode, 2'b00);
    tst_en_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    t_powerup;
    t_walk;
    t_leave_test;
    t_hiz;
    t_priority;
    t_between_edges;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule